// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory whose words are split into byte lanes. Each lane holds eight data bits and one parity bit, so the default word is 36 bits wide in four lanes. Every rising clock edge registers the address, the write data, the write controls and three chip-select inputs. A read is flow-through: the word at the captured address appears on the output during the cycle that follows that edge, with no output register. A write captured at one edge is committed to the array at the next edge and needs no further handshake.

Write lanes are chosen in two levels. A global write input forces every lane to be written. Otherwise the per-lane enables count only while a lane-write gate input is active. Three chip selects of mixed polarity must all be active for any read or write to take place. The output enable is asynchronous. The data pins are presented as a value and a drive enable, ready for a pad ring. Array depth, lane count, lane widths and the bit layout of the lanes within a word are parameters.

Top module: `lane_sram`

## Requirements
- R1: A read is flow-through. When selected with `out_en_n` low, `rdata` shows the word stored at the address captured at the most recent rising edge, during the cycle that follows that edge.
- R2: An access takes place only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 were captured together. If any one of them is inactive, nothing is written and `rdata_drive` stays low for that cycle.
- R3: In a selected cycle with `wr_all_n`=0, all lanes are written, whatever `lane_gate_n` and `lane_wr_n` are.
- R4: In a selected cycle with `wr_all_n`=1 and `lane_gate_n`=0, lane k is written if and only if `lane_wr_n[k]`=0. Lanes whose enable is 1 keep their stored bits.
- R5: In a cycle with `wr_all_n`=1 and `lane_gate_n`=1, no lane is written, whatever `lane_wr_n` is.
- R6: In the default layout, lane k carries data bits `wdata[8k+7:8k]` and parity bit `wdata[32+k]`, and `rdata` uses the same positions. `lane_wr_n[k]` controls exactly those nine bits.
- R7: During the cycle in which a write is captured, `rdata` shows the contents of the addressed word from before that write.
- R8: A write completes without further handshake. A read of the same address captured at the very next edge returns the new data.
- R9: `out_en_n` acts without a clock. While it is 1, `rdata_drive` is 0 and `rdata` is all zeros. Returning it to 0 within the same cycle restores the read word.
- R10: While `rst_n` is low, and after it is released until a selected access is captured, `rdata_drive` is 0 and no write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the capture registers |
| addr | input | ADDR_W | Word address, registered each edge |
| wdata | input | WORD_W | Write word (data bytes and parity bits), registered each edge |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low, writes every lane |
| lane_gate_n | input | 1 | Lane-write gate, active low, enables `lane_wr_n` |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | WORD_W | Read word, all zeros while not driven |
| rdata_drive | output | 1 | High when the data pins drive; low means high impedance |

## Verification
The bench goes after the lane boundaries: for each lane in turn it writes an inverted pattern through that lane alone. A lane map with shifted parity positions, or a decoder that mixes up lane indices, then corrupts a neighbour's byte or parity bit. It also checks that the global write overrides a closed gate and all-inactive lane enables, and that open lane enables do nothing while the gate is closed. A decoder with the wrong precedence writes too much or too little. Each chip select is dropped alone during a write, to catch a polarity slip that would let a deselected write through. The read in the cycle of a write must show old data and the next read the new word. A design that wrote at the capture edge would show new data too early, and one that delayed the commit would show stale data one cycle late.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

   // Bit layout of the lanes inside a word
   typedef enum logic {
      LAYOUT_PARITY_TOP  = 1'b0,  // data bytes low, parity bits grouped at the top
      LAYOUT_INTERLEAVED = 1'b1   // each lane is one contiguous field
   } lane_layout_e;

   // Registered write/select controls common to all lanes
   typedef struct packed {
      logic sel;
      logic wr_all_n;
      logic gate_n;
   } wr_ctrl_t;

   function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
      return (~a_n) & b & (~c_n);
   endfunction

endpackage

// File: rtl/lane_sram_capture.sv
module lane_sram_capture
   import lane_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [WORD_W-1:0] wdata_d,
   input  wr_ctrl_t          ctrl_d,
   input  logic [LANES-1:0]  lane_wr_n_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [WORD_W-1:0] wdata_q,
   output wr_ctrl_t          ctrl_q,
   output logic [LANES-1:0]  lane_wr_n_q
);

   localparam wr_ctrl_t CTRL_IDLE = '{sel: 1'b0, wr_all_n: 1'b1, gate_n: 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         wdata_q     <= '0;
         ctrl_q      <= CTRL_IDLE;
         lane_wr_n_q <= '1;
      end else begin
         addr_q      <= addr_d;
         wdata_q     <= wdata_d;
         ctrl_q      <= ctrl_d;
         lane_wr_n_q <= lane_wr_n_d;
      end
   end

endmodule

// File: rtl/lane_sram_wr_decode.sv
module lane_sram_wr_decode
   import lane_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  wr_ctrl_t         ctrl,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_we
);

   logic global_wr;
   logic gate_open;

   assign global_wr = ~ctrl.wr_all_n;
   assign gate_open = ~ctrl.gate_n;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_we[k] = ctrl.sel & (global_wr | (gate_open & ~lane_wr_n[k]));
   end

endmodule

// File: rtl/lane_sram_lane_map.sv
module lane_sram_lane_map
   import lane_sram_pkg::*;
#(
   parameter int           LANES       = 4,
   parameter int           LANE_DATA_W = 8,
   parameter int           LANE_PAR_W  = 1,
   parameter lane_layout_e LAYOUT      = LAYOUT_PARITY_TOP,
   localparam int          LANE_W      = LANE_DATA_W + LANE_PAR_W,
   localparam int          WORD_W      = LANES * LANE_W
) (
   input  logic [WORD_W-1:0]             word_in,
   output logic [LANES-1:0][LANE_W-1:0]  lanes_out,
   input  logic [LANES-1:0][LANE_W-1:0]  lanes_in,
   output logic [WORD_W-1:0]             word_out
);

   localparam int PAR_BASE = LANES * LANE_DATA_W;

   if (LAYOUT == LAYOUT_PARITY_TOP) begin : g_parity_top
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lanes_out[k] = {word_in[PAR_BASE + LANE_PAR_W*k +: LANE_PAR_W],
                                word_in[LANE_DATA_W*k +: LANE_DATA_W]};
         assign word_out[LANE_DATA_W*k +: LANE_DATA_W]            = lanes_in[k][LANE_DATA_W-1:0];
         assign word_out[PAR_BASE + LANE_PAR_W*k +: LANE_PAR_W]   = lanes_in[k][LANE_W-1:LANE_DATA_W];
      end
   end else begin : g_interleaved
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lanes_out[k]                   = word_in[LANE_W*k +: LANE_W];
         assign word_out[LANE_W*k +: LANE_W]   = lanes_in[k];
      end
   end

endmodule

// File: rtl/lane_sram_lane_store.sv
module lane_sram_lane_store #(
   parameter int  ADDR_W = 8,
   parameter int  LANE_W = 9,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);

   logic [LANE_W-1:0] mem [DEPTH];

   // Commit of a write captured one edge earlier
   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   // Flow-through read of the captured address: shows pre-commit contents
   assign rdata = mem[addr];

   AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(addr)] == $past(wdata))) else $error("lane write lost"); // R4
   AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (mem[$past(addr)] == $past(mem[addr]))) else $error("lane changed without enable"); // R5

endmodule

// File: rtl/lane_sram.sv
module lane_sram
   import lane_sram_pkg::*;
#(
   parameter int           ADDR_W      = 8,
   parameter int           LANES       = 4,
   parameter int           LANE_DATA_W = 8,
   parameter int           LANE_PAR_W  = 1,
   parameter lane_layout_e LAYOUT      = LAYOUT_PARITY_TOP,
   localparam int          LANE_W      = LANE_DATA_W + LANE_PAR_W,
   localparam int          WORD_W      = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_all_n,
   input  logic              lane_gate_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic              out_en_n,
   output logic [WORD_W-1:0] rdata,
   output logic              rdata_drive
);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("lane_sram: ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("lane_sram: LANES must lie in 1..16");
   end
   if (LANE_DATA_W < 1 || LANE_PAR_W < 1) begin : g_bad_lane_w
      $error("lane_sram: lane field widths must be at least 1");
   end

   wr_ctrl_t          ctrl_d;
   wr_ctrl_t          ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic [LANES-1:0]  lane_wr_n_q;
   logic [LANES-1:0]  lane_we;
   logic [LANES-1:0][LANE_W-1:0] wr_lanes;
   logic [LANES-1:0][LANE_W-1:0] rd_lanes;
   logic [WORD_W-1:0] rd_word;

   assign ctrl_d.sel      = chip_selected(sel_a_n, sel_b, sel_c_n);
   assign ctrl_d.wr_all_n = wr_all_n;
   assign ctrl_d.gate_n   = lane_gate_n;

   lane_sram_capture #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .LANES  (LANES)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_d      (addr),
      .wdata_d     (wdata),
      .ctrl_d      (ctrl_d),
      .lane_wr_n_d (lane_wr_n),
      .addr_q      (addr_q),
      .wdata_q     (wdata_q),
      .ctrl_q      (ctrl_q),
      .lane_wr_n_q (lane_wr_n_q)
   );

   lane_sram_wr_decode #(
      .LANES (LANES)
   ) u_decode (
      .ctrl      (ctrl_q),
      .lane_wr_n (lane_wr_n_q),
      .lane_we   (lane_we)
   );

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.sel |-> (lane_we == '0)) else $error("write while deselected"); // R2
   AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.sel && !ctrl_q.wr_all_n) |-> (&lane_we)) else $error("global write missed a lane"); // R3
   AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wr_all_n && ctrl_q.gate_n) |-> (lane_we == '0)) else $error("lane write with gate closed"); // R5

   lane_sram_lane_map #(
      .LANES       (LANES),
      .LANE_DATA_W (LANE_DATA_W),
      .LANE_PAR_W  (LANE_PAR_W),
      .LAYOUT      (LAYOUT)
   ) u_map (
      .word_in   (wdata_q),
      .lanes_out (wr_lanes),
      .lanes_in  (rd_lanes),
      .word_out  (rd_word)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_store
      lane_sram_lane_store #(
         .ADDR_W (ADDR_W),
         .LANE_W (LANE_W)
      ) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (lane_we[k]),
         .addr  (addr_q),
         .wdata (wr_lanes[k]),
         .rdata (rd_lanes[k])
      );
   end

   // Asynchronous output enable gates the flow-through word
   assign rdata_drive = ctrl_q.sel & ~out_en_n;
   assign rdata       = rdata_drive ? rd_word : '0;

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.sel |-> (rdata == '0)) else $error("data present while deselected"); // R2

endmodule

// File: tb/lane_sram_bench.sv
`timescale 1ns/1ps
module lane_sram_bench;

   localparam int AW = 8;
   localparam int WW = 36;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] wdata = '0;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b0;
   logic          sel_c_n = 1'b1;
   logic          wr_all_n = 1'b1;
   logic          lane_gate_n = 1'b1;
   logic [NL-1:0] lane_wr_n = '1;
   logic          out_en_n = 1'b0;
   logic [WW-1:0] rdata;
   logic          rdata_drive;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   logic [WW-1:0] model [1<<AW];

   always #2 clk = ~clk;

   lane_sram u_lane_sram (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
      .sel_a_n (sel_a_n), .sel_b (sel_b), .sel_c_n (sel_c_n),
      .wr_all_n (wr_all_n), .lane_gate_n (lane_gate_n), .lane_wr_n (lane_wr_n),
      .out_en_n (out_en_n), .rdata (rdata), .rdata_drive (rdata_drive)
   );

   task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Lane k in the default layout: bits 8k..8k+7 and parity bit 32+k (R6)
   function automatic logic [WW-1:0] lane_mask(input int k);
      logic [WW-1:0] m;
      m = '0;
      m[8*k +: 8] = 8'hFF;
      m[32+k]     = 1'b1;
      return m;
   endfunction

   // One clock of stimulus; checks the flow-through output and updates the model
   task automatic op(input logic [AW-1:0] a, input logic [WW-1:0] d,
                     input logic sa_n, input logic sb, input logic sc_n,
                     input logic wa_n, input logic g_n, input logic [NL-1:0] lw_n,
                     input string tag);
      logic sel;
      logic [WW-1:0] m;
      @(negedge clk);
      addr = a; wdata = d; sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
      wr_all_n = wa_n; lane_gate_n = g_n; lane_wr_n = lw_n;
      @(posedge clk);
      #1;
      sel = !sa_n && sb && !sc_n;
      chk({tag, " drive"}, {35'd0, rdata_drive}, {35'd0, sel && !out_en_n});
      if (sel && !out_en_n) chk({tag, " data"}, rdata, model[a]);
      else                  chk({tag, " zero"}, rdata, '0);
      if (sel) begin
         m = '0;
         for (int k = 0; k < NL; k++)
            if (!wa_n || (!g_n && !lw_n[k])) m |= lane_mask(k);
         model[a] = (model[a] & ~m) | (d & m);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      op(a, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, tag);
   endtask

   task automatic wr_all(input logic [AW-1:0] a, input logic [WW-1:0] d, input string tag);
      op(a, d, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, tag);
   endtask

   task automatic t_reset();
      // R10: selected global write presented during reset must do nothing
      addr = 8'd0; wdata = '1; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; wr_all_n = 1'b0;
      repeat (3) begin
         @(posedge clk); #1;
         chk("R10 drive in reset", {35'd0, rdata_drive}, '0);
         chk("R10 data in reset", rdata, '0);
      end
      @(negedge clk);
      sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; wr_all_n = 1'b1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R10 drive after release", {35'd0, rdata_drive}, '0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 32; i++) model[i] = 'x;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         addr = AW'(i); wdata = {4'(i), 32'hA5000000 | 32'(i * 32'h010203)};
         sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; wr_all_n = 1'b0; lane_gate_n = 1'b1; lane_wr_n = '1;
         @(posedge clk);
         model[i] = wdata;
      end
      for (int i = 0; i < 32; i++) rd(AW'(i), "R1 R3 fill readback");
   endtask

   task automatic t_global_override();
      // R3: global write beats a closed gate and inactive lane enables
      op(8'd40, 36'hF_1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1111, "R3 prime");
      op(8'd40, 36'h0_89AB_CDEF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1111, "R3 override old");
      rd(8'd40, "R3 override readback");
      op(8'd40, 36'h5_0F0F_0F0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, "R3 with gate open");
      rd(8'd40, "R3 readback 2");
   endtask

   task automatic t_lanes();
      // R4 R6: each lane alone, data byte and parity bit
      for (int k = 0; k < NL; k++) begin
         wr_all(8'd50, 36'h0_0000_0000, "R4 prime");
         op(8'd50, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ~(4'b1 << k), "R6 lane write");
         rd(8'd50, "R4 R6 single lane readback");
         chk("R6 lane bits", rdata, lane_mask(k));
      end
      // two lanes at once on a patterned word
      wr_all(8'd51, 36'hA_5A5A_5A5A, "R4 prime2");
      op(8'd51, 36'h5_C3C3_C3C3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, "R4 two lanes");
      rd(8'd51, "R4 two lane readback");
   endtask

   task automatic t_gate_closed();
      // R5: open lane enables, gate closed, no global write
      wr_all(8'd60, 36'h3_1111_2222, "R5 prime");
      op(8'd60, 36'hC_EEEE_DDDD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, "R5 gate closed");
      rd(8'd60, "R5 unchanged");
      chk("R5 word", rdata, 36'h3_1111_2222);
   endtask

   task automatic t_select();
      // R2: each chip select dropped alone during a global write
      wr_all(8'd70, 36'h9_8765_4321, "R2 prime");
      op(8'd70, 36'h0_DEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R2 a inactive");
      op(8'd70, 36'h0_DEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, "R2 b inactive");
      op(8'd70, 36'h0_DEAD_BEEF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R2 c inactive");
      rd(8'd70, "R2 unchanged");
      chk("R2 word", rdata, 36'h9_8765_4321);
   endtask

   task automatic t_rbw();
      // R7: write cycle shows old data; R8: next-edge read shows new data
      wr_all(8'd80, 36'h1_0101_0101, "R7 prime");
      wr_all(8'd80, 36'hE_FEFE_FEFE, "R7 old during write");
      rd(8'd80, "R8 new at next read");
      chk("R8 word", rdata, 36'hE_FEFE_FEFE);
      op(8'd80, 36'h0_0000_00FF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110, "R7 lane write shows old");
      rd(8'd80, "R8 lane result");
   endtask

   task automatic t_oe();
      // R9: output enable without a clock edge
      rd(8'd5, "R9 read");
      #0.3 out_en_n = 1'b1;
      #0.2;
      chk("R9 drive off", {35'd0, rdata_drive}, '0);
      chk("R9 zero", rdata, '0);
      out_en_n = 1'b0;
      #0.2;
      chk("R9 drive on", {35'd0, rdata_drive}, 36'd1);
      chk("R9 data back", rdata, model[5]);
      @(negedge clk); out_en_n = 1'b1;
      rd(8'd6, "R9 read with oe off");
      @(negedge clk); out_en_n = 1'b0;
   endtask

   initial begin
      t_reset();
      t_fill();
      t_global_override();
      t_lanes();
      t_gate_closed();
      t_select();
      t_rbw();
      t_oe();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule